// File: doc/BRIEF.md
# Serial LED-Driver Register Interface

This block is the serial front end of a sixteen-channel LED sink driver. A host clocks a sixteen-bit word into a common shift register, one bit per serial clock rising edge, and then raises a latch strobe. The level of the serial clock at the moment the latch strobe rises picks where the word goes. With the clock low, the word becomes the per-channel on/off pattern. With the clock high, the word becomes the function-control word, and its fields are presented as outputs for the analog section: power-save enable, detection time, detection current, short threshold, blank mode, status-load select and global brightness.

All pins are brought into a fast system clock domain through synchronizer chains, and the serial clock and latch edges become single-cycle strobes. The blank pin has two meanings, chosen by the blank-mode control bit. In one mode it selects whether the serial output taps bit 7 or bit 15, so that a string of drivers can run as eight-channel or sixteen-channel parts. In the other mode it forces every channel off. An on/off write can replace the shift register contents with a status word supplied on an input port, so that the host reads the status back while it shifts in the next frame.

Top module: `ledsr_frontend`

## Requirements
- R1: After reset the shift register and the channel enables are all zero, and the control fields read as the word 16'hE67F in the order psave[15], det_time[14:13], det_cur[12:11], short_sel[10], blank_mode[9], stat_sel[8:7], brightness[6:0].
- R2: Each serial clock rising edge moves the shift register one place toward bit 15 and puts the serial input into bit 0.
- R3: A latch rising edge with the serial clock low copies the shift register into the on/off latch, and the control fields stay unchanged.
- R4: A latch rising edge with the serial clock high copies the shift register into the control latch, bit positions as in R1, and the on/off latch stays unchanged.
- R5: The serial output shows bit 7 when blank_mode is 0 and blank is low; in every other case it shows bit 15.
- R6: When blank_mode is 1 and blank is high, every channel enable is 0 and the on/off latch keeps its value; otherwise each enable equals its on/off bit.
- R7: A control write made while blank_mode is 0 and blank is low has no effect on the control fields.
- R8: An on/off write with stat_sel not equal to 00 and shift register bit 15 equal to 0 reloads the shift register with the status word.
- R9: An on/off write with stat_sel equal to 00, or with bit 15 equal to 1, leaves the shift register contents unchanged.
- R10: A control write never reloads the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sclk | input | 1 | Serial shift clock pin |
| pin_lat | input | 1 | Latch strobe pin |
| pin_blank | input | 1 | Blank / tap-select pin |
| pin_sin | input | 1 | Serial data input pin |
| status_word | input | 16 | Status word to load into the shift register on an on/off write |
| sout | output | 1 | Serial data output |
| chan_en | output | 16 | Per-channel output enables |
| psave_en | output | 1 | Power-save enable field |
| det_time | output | 2 | Detection time select field |
| det_cur | output | 2 | Detection current select field |
| short_sel | output | 1 | Short-threshold select field |
| blank_mode | output | 1 | Blank-mode field |
| stat_sel | output | 2 | Status-load select field |
| brightness | output | 7 | Global brightness field |

## Verification
The bench sweeps all four status-load selections against both values of the shift register MSB; a design that inverted the MSB guard or reloaded on select 00 would return the status word where the host's own data should come back, or the reverse. It moves the blank pin under both blank modes with bit 7 and bit 15 set apart, which exposes a serial output tied to the wrong tap or a blank that forces outputs off in the wrong mode. It writes control words while blank mode is 0 and blank is low, where a design lacking the write guard would change the fields, and it reads the shift register back after a control write to catch a reload on the wrong destination.

// File: rtl/ledsr_pkg.sv
package ledsr_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic       psave;
    logic [1:0] det_time;
    logic [1:0] det_cur;
    logic       short_sel;
    logic       blank_mode;
    logic [1:0] stat_sel;
    logic [6:0] bright;
  } ctrl_t;

  localparam logic [WORD_W-1:0] CTRL_DEFAULT = 16'hE67F;
endpackage

// File: rtl/ledsr_sync.sv
module ledsr_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/ledsr_shift.sv
module ledsr_shift
  import ledsr_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_rise,
  input  logic         lat_rise,
  input  logic         sclk_lvl,
  input  logic         sin,
  input  logic [1:0]   stat_sel,
  input  logic [W-1:0] status_word,
  output logic [W-1:0] sr
);
  localparam int MSB = W - 1;

  logic onoff_wr;
  logic do_reload;

  assign onoff_wr  = lat_rise && !sclk_lvl;
  assign do_reload = onoff_wr && (stat_sel != 2'b00) && !sr[MSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (do_reload) begin
      sr <= status_word;
    end else if (sclk_rise) begin
      sr <= {sr[MSB-1:0], sin};
    end
  end

  a_r2_lsb_in: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !lat_rise) |=> (sr[0] == $past(sin)));
  a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
    (onoff_wr && !sclk_rise && ((stat_sel == 2'b00) || sr[MSB])) |=> $stable(sr));
  a_r10_ctrl_no_reload: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && sclk_lvl && !sclk_rise) |=> $stable(sr));
endmodule

// File: rtl/ledsr_latches.sv
module ledsr_latches
  import ledsr_pkg::*;
#(
  parameter int W = WORD_W,
  parameter logic [W-1:0] CTRL_INIT = CTRL_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lat_rise,
  input  logic         sclk_lvl,
  input  logic         blank_lvl,
  input  logic [W-1:0] sr,
  output logic [W-1:0] onoff_q,
  output ctrl_t        ctrl_q
);
  logic ctrl_locked;

  assign ctrl_locked = !ctrl_q.blank_mode && !blank_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      onoff_q <= '0;
    end else if (lat_rise && !sclk_lvl) begin
      onoff_q <= sr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= ctrl_t'(CTRL_INIT);
    end else if (lat_rise && sclk_lvl && !ctrl_locked) begin
      ctrl_q <= ctrl_t'(sr);
    end
  end

  a_r3_onoff_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !(lat_rise && !sclk_lvl) |=> $stable(onoff_q));
  a_r4_ctrl_untouched_by_onoff: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && !sclk_lvl) |=> $stable(ctrl_q));
  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.blank_mode && !blank_lvl) |=> $stable(ctrl_q));
endmodule

// File: rtl/ledsr_frontend.sv
module ledsr_frontend
  import ledsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NARROW_TAP  = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pin_sclk,
  input  logic        pin_lat,
  input  logic        pin_blank,
  input  logic        pin_sin,
  input  logic [15:0] status_word,
  output logic        sout,
  output logic [15:0] chan_en,
  output logic        psave_en,
  output logic [1:0]  det_time,
  output logic [1:0]  det_cur,
  output logic        short_sel,
  output logic        blank_mode,
  output logic [1:0]  stat_sel,
  output logic [6:0]  brightness
);
  localparam int W       = WORD_W;
  localparam int WIDE_TAP = W - 1;
  localparam int NPINS   = 4;
  localparam int P_SCLK  = 0;
  localparam int P_LAT   = 1;
  localparam int P_BLANK = 2;
  localparam int P_SIN   = 3;

  logic [NPINS-1:0] pin_level, pin_rise;
  logic [W-1:0]     status_q;
  logic [W-1:0]     sr;
  logic [W-1:0]     onoff_q;
  ctrl_t            ctrl_q;
  logic             wide_tap_sel;
  logic             force_off;

  ledsr_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   ({pin_sin, pin_blank, pin_lat, pin_sclk}),
    .level (pin_level),
    .rise  (pin_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_word;
  end

  ledsr_shift #(.W(W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .sclk_rise   (pin_rise[P_SCLK]),
    .lat_rise    (pin_rise[P_LAT]),
    .sclk_lvl    (pin_level[P_SCLK]),
    .sin         (pin_level[P_SIN]),
    .stat_sel    (ctrl_q.stat_sel),
    .status_word (status_q),
    .sr          (sr)
  );

  ledsr_latches #(.W(W), .CTRL_INIT(CTRL_DEFAULT)) u_latches (
    .clk       (clk),
    .rst       (rst),
    .lat_rise  (pin_rise[P_LAT]),
    .sclk_lvl  (pin_level[P_SCLK]),
    .blank_lvl (pin_level[P_BLANK]),
    .sr        (sr),
    .onoff_q   (onoff_q),
    .ctrl_q    (ctrl_q)
  );

  assign wide_tap_sel = ctrl_q.blank_mode || pin_level[P_BLANK];
  assign force_off    = ctrl_q.blank_mode && pin_level[P_BLANK];

  always_ff @(posedge clk) begin
    if (rst) begin
      sout    <= 1'b0;
      chan_en <= '0;
    end else begin
      sout    <= wide_tap_sel ? sr[WIDE_TAP] : sr[NARROW_TAP];
      chan_en <= force_off ? '0 : onoff_q;
    end
  end

  assign psave_en   = ctrl_q.psave;
  assign det_time   = ctrl_q.det_time;
  assign det_cur    = ctrl_q.det_cur;
  assign short_sel  = ctrl_q.short_sel;
  assign blank_mode = ctrl_q.blank_mode;
  assign stat_sel   = ctrl_q.stat_sel;
  assign brightness = ctrl_q.bright;

  a_r6_forced_off: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.blank_mode && pin_level[P_BLANK]) |=> (chan_en == '0));
  a_r6_follow_latch: assert property (@(posedge clk) disable iff (rst)
    (!pin_level[P_BLANK] && $stable(onoff_q)) |=> (chan_en == $past(onoff_q)));
endmodule

// File: tb/ledsr_frontend_bench.sv
module ledsr_frontend_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_sclk = 1'b0, pin_lat = 1'b0, pin_blank = 1'b0, pin_sin = 1'b0;
  logic [15:0] status_word = '0;
  logic sout;
  logic [15:0] chan_en;
  logic psave_en, short_sel, blank_mode;
  logic [1:0] det_time, det_cur, stat_sel;
  logic [6:0] brightness;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ledsr_frontend u_ledsr_frontend (
    .clk(clk), .rst(rst), .pin_sclk(pin_sclk), .pin_lat(pin_lat),
    .pin_blank(pin_blank), .pin_sin(pin_sin), .status_word(status_word),
    .sout(sout), .chan_en(chan_en), .psave_en(psave_en), .det_time(det_time),
    .det_cur(det_cur), .short_sel(short_sel), .blank_mode(blank_mode),
    .stat_sel(stat_sel), .brightness(brightness)
  );

  function automatic logic [15:0] fields();
    return {psave_en, det_time, det_cur, short_sel, blank_mode, stat_sel, brightness};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic shift_word(input logic [15:0] w, input bit leave_high);
    for (int i = 15; i >= 0; i--) begin
      pin_sin = w[i];
      settle();
      pin_sclk = 1'b1;
      settle();
      if (!(i == 0 && leave_high)) begin
        pin_sclk = 1'b0;
        settle();
      end
    end
    pin_sin = 1'b0;
  endtask

  task automatic pulse_lat();
    pin_lat = 1'b1;
    settle();
    pin_lat = 1'b0;
    settle();
  endtask

  task automatic write_onoff(input logic [15:0] w);
    shift_word(w, 1'b0);
    pulse_lat();
  endtask

  task automatic write_ctrl(input logic [15:0] w);
    shift_word(w, 1'b1);
    pulse_lat();
    pin_sclk = 1'b0;
    settle();
  endtask

  task automatic read_sr(output logic [15:0] v);
    pin_sin = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      v[i] = sout;
      pin_sclk = 1'b1;
      settle();
      pin_sclk = 1'b0;
      settle();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, pat, exp_sr, cw;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    settle();

    // R1: reset state
    chk("R1 fields", fields(), 16'hE67F);
    chk("R1 chan_en", chan_en, 16'h0000);
    chk("R1 sout", {15'b0, sout}, 16'h0000);

    // R2/R3: walking ones plus assorted patterns to the on/off latch
    pin_blank = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pat = 16'h0001 << i;
      write_onoff(pat);
      chk("R2 R3 walking one", chan_en, pat);
    end
    write_onoff(16'hFFFF); chk("R2 all ones", chan_en, 16'hFFFF);
    write_onoff(16'h6C39); chk("R3 pattern", chan_en, 16'h6C39);
    chk("R3 ctrl unchanged", fields(), 16'hE67F);

    // R4: control writes, blank_mode kept at 1
    for (int b = 0; b < 128; b += 21) begin
      cw = 16'h0200 | (16'(b) & 16'h007F) | (16'(b) << 10 & 16'hFC00);
      cw[9] = 1'b1;
      cw[8:7] = 2'b00;
      write_ctrl(cw);
      chk("R4 ctrl fields", fields(), cw);
      chk("R4 onoff kept", chan_en, 16'h6C39);
    end

    // R5: tap selection
    pin_blank = 1'b1;
    settle();
    write_ctrl(16'h0000);            // blank_mode 0 (write allowed: blank high)
    chk("R5 bm0 set", fields(), 16'h0000);
    shift_word(16'h0080, 1'b0);
    chk("R5 bm0 blank high bit15", {15'b0, sout}, 16'h0000);
    pin_blank = 1'b0; settle();
    chk("R5 bm0 blank low bit7", {15'b0, sout}, 16'h0001);
    shift_word(16'h8000, 1'b0);
    chk("R5 bm0 blank low bit7 clear", {15'b0, sout}, 16'h0000);
    pin_blank = 1'b1; settle();
    chk("R5 bm0 blank high bit15 set", {15'b0, sout}, 16'h0001);
    write_ctrl(16'h0200);            // blank_mode 1
    pin_blank = 1'b0; settle();
    shift_word(16'h0080, 1'b0);
    chk("R5 bm1 blank low bit15", {15'b0, sout}, 16'h0000);
    shift_word(16'h8000, 1'b0);
    chk("R5 bm1 blank low bit15 set", {15'b0, sout}, 16'h0001);

    // R7: control write ignored with blank_mode 0 and blank low
    pin_blank = 1'b1; settle();
    write_ctrl(16'h0000);
    pin_blank = 1'b0; settle();
    write_ctrl(16'h027F);
    chk("R7 ignored write", fields(), 16'h0000);
    pin_blank = 1'b1; settle();
    write_ctrl(16'h027F);
    chk("R7 accepted write", fields(), 16'h027F);

    // R6: forced off only with blank_mode 1 and blank high
    pin_blank = 1'b0; settle();
    write_onoff(16'hC3A5);
    chk("R6 blank low follows", chan_en, 16'hC3A5);
    pin_blank = 1'b1; settle();
    chk("R6 forced off", chan_en, 16'h0000);
    pin_blank = 1'b0; settle();
    chk("R6 latch preserved", chan_en, 16'hC3A5);
    pin_blank = 1'b1; settle();
    write_ctrl(16'h0000);
    chk("R6 bm0 blank high no force", chan_en, 16'hC3A5);
    write_ctrl(16'h0200);
    pin_blank = 1'b0; settle();

    // R8/R9: reload sweep over select and MSB
    status_word = 16'h3C96;
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        cw = 16'h0210 | (16'(s) << 7);
        write_ctrl(cw);
        chk("R4 sel write", {14'b0, stat_sel}, 16'(s));
        pat = (m != 0) ? 16'h8421 : 16'h0421;
        write_onoff(pat);
        chk("R3 reload sweep onoff", chan_en, pat);
        read_sr(rd);
        exp_sr = (s != 0 && m == 0) ? 16'h3C96 : pat;
        if (s != 0 && m == 0) chk("R8 reload", rd, exp_sr);
        else                  chk("R9 no reload", rd, exp_sr);
      end
    end

    // R10: control write with a nonzero select leaves the word in place
    write_ctrl(16'h0290);
    chk("R10 sel applied", fields(), 16'h0290);
    read_sr(rd);
    chk("R10 no reload on ctrl", rd, 16'h0290);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule